// File: doc/BRIEF.md
# Memory ECC Error Injection Unit

This unit sits on the write path of a memory controller, between the ECC encoder and the storage array. It deliberately damages the stored check bits, the per-section parity bits, or both, so that the error detection and reporting logic downstream can be exercised on real traffic. Software sets up a filter on the access address. The filter has six fields: DIMM within channel, rank, channel, bank, page and column. Each field holds either a specific value or a wildcard. Software also sets an XOR pattern for the check bits, a section select, a type field and an arm bit.

While armed, each access that passes the filter is a trigger. A triggering write leaves with its check bits and/or parity altered in the same cycle. `inj_event` pulses in that cycle, and a 16-bit saturating injection counter advances on the following edge. In one-shot mode the unit disarms itself after the first trigger. In repeat mode it keeps corrupting until software disarms it. An optional read-trigger setting lets matching reads raise the event and count as well. Reads are never altered.

Top module: `ecc_inject_unit`

## Requirements
- R1: After reset, every match register reads back with bit 31 (wildcard) set and a zero value, and the section, type, mask, arm, read-trigger and count registers all read zero.
- R2: An access matches only when every field whose wildcard bit is clear equals the access's field. A field with its wildcard bit set matches any value. Match register offsets are 0 dimm, 1 rank, 2 channel, 3 bank, 4 page, 5 column; the value sits in the low bits.
- R3: On a triggering write with type bit 1 set, `chk_out` is `chk_in` XOR (mask AND lanes). Lanes are chosen by the section register at offset 7: 1 selects the low half of the check bits, 2 the high half, 3 both, and 0 none. Without a trigger, `chk_out` equals `chk_in`.
- R4: On a triggering write with type bit 2 set, `par_out` is `par_in` XOR section. `par_out` bit 0 belongs to the low section and bit 1 to the high section.
- R5: A write of any nonzero value to the arm register (offset 9) arms the unit and reads back as 1. A write of zero disarms it. No access triggers while the unit is disarmed.
- R6: With type bit 0 (repeat) clear, the first trigger disarms the unit on the next edge, so a later matching write passes unaltered.
- R7: With repeat set, every matching write is corrupted while the unit stays armed.
- R8: Reads are never altered. A matching read triggers only when bit 0 of the read-trigger register (offset 10) is set, and that bit is zero after reset.
- R9: The count register (offset 11) advances by one per trigger and saturates at 0xFFFF. Any write to it clears it, and the clear takes precedence over a trigger in the same cycle.
- R10: The registers read back what was written: mask (offset 6), section, type (offset 8), read-trigger, and match values truncated to their field width.
- R11: `inj_event` is high in exactly the cycle of a triggering access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dimm | input | 2 | DIMM number within the channel |
| acc_rank | input | 2 | Rank |
| acc_chan | input | 2 | Channel |
| acc_bank | input | 3 | Bank |
| acc_page | input | 16 | Page (row) address |
| acc_col | input | 12 | Column address |
| chk_in | input | 16 | Check bits from the encoder |
| par_in | input | 2 | Section parity bits from the encoder |
| chk_out | output | 16 | Check bits to storage |
| par_out | output | 2 | Parity bits to storage |
| inj_event | output | 1 | Trigger pulse |

## Verification
The case hardest to reach from the ports is counter saturation. Reaching it takes 65535 triggers, and a clear arriving in that stream must still win over a trigger. The bench arms repeat mode and holds a matching write on the bus for more than 65535 cycles. It then reads 0xFFFF back and clears the counter. A second hard case is the one-shot disarm: it can only be seen on the access after the trigger, so the bench follows each one-shot trigger with a second matching write and reads back the arm register.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int CFG_AW     = 4;
  localparam int CFG_DW     = 32;
  localparam int ANY_BIT    = 31;

  // type field bit positions
  localparam int TYP_REPEAT = 0;
  localparam int TYP_ECC    = 1;
  localparam int TYP_PAR    = 2;

  typedef enum logic [CFG_AW-1:0] {
    RA_DIMM   = 4'd0,
    RA_RANK   = 4'd1,
    RA_CHAN   = 4'd2,
    RA_BANK   = 4'd3,
    RA_PAGE   = 4'd4,
    RA_COL    = 4'd5,
    RA_MASK   = 4'd6,
    RA_SECT   = 4'd7,
    RA_TYPE   = 4'd8,
    RA_ARM    = 4'd9,
    RA_RDTRIG = 4'd10,
    RA_CNT    = 4'd11
  } reg_addr_e;

  function automatic int fmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ecc_inj_cfg.sv
module ecc_inj_cfg
  import ecc_inj_pkg::*;
#(
  parameter int MAXW  = 16,
  parameter int CHK_W = 16,
  parameter int CNT_W = 16,
  parameter logic [NUM_FIELDS-1:0][MAXW-1:0] FLD_MASK = '1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_wr,
  input  logic [CFG_AW-1:0]                cfg_addr,
  input  logic [CFG_DW-1:0]                cfg_wdata,
  output logic [CFG_DW-1:0]                cfg_rdata,
  input  logic                             trig,
  output logic [NUM_FIELDS-1:0][MAXW-1:0]  fld_val,
  output logic [NUM_FIELDS-1:0]            fld_any,
  output logic [CHK_W-1:0]                 mask_q,
  output logic [1:0]                       sect_q,
  output logic [2:0]                       type_q,
  output logic                             armed_q,
  output logic                             rdtrig_q,
  output logic [CNT_W-1:0]                 cnt_q
);
  logic arm_wr, cnt_wr, nonzero_wdata;

  assign arm_wr        = cfg_wr && (cfg_addr == RA_ARM);
  assign cnt_wr        = cfg_wr && (cfg_addr == RA_CNT);
  assign nonzero_wdata = |cfg_wdata;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_val  <= '0;
      fld_any  <= '1;
      mask_q   <= '0;
      sect_q   <= '0;
      type_q   <= '0;
      armed_q  <= 1'b0;
      rdtrig_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (cfg_wr && (cfg_addr == CFG_AW'(i))) begin
          fld_val[i] <= cfg_wdata[MAXW-1:0] & FLD_MASK[i];
          fld_any[i] <= cfg_wdata[ANY_BIT];
        end
      end
      if (cfg_wr && (cfg_addr == RA_MASK))   mask_q   <= cfg_wdata[CHK_W-1:0];
      if (cfg_wr && (cfg_addr == RA_SECT))   sect_q   <= cfg_wdata[1:0];
      if (cfg_wr && (cfg_addr == RA_TYPE))   type_q   <= cfg_wdata[2:0];
      if (cfg_wr && (cfg_addr == RA_RDTRIG)) rdtrig_q <= cfg_wdata[0];

      if (arm_wr)                            armed_q <= nonzero_wdata;
      else if (trig && !type_q[TYP_REPEAT])  armed_q <= 1'b0;

      if (cnt_wr)    cnt_q <= '0;
      else if (trig) cnt_q <= sat_inc(cnt_q);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (cfg_addr == CFG_AW'(i)) begin
        cfg_rdata[MAXW-1:0] = fld_val[i];
        cfg_rdata[ANY_BIT]  = fld_any[i];
      end
    end
    case (cfg_addr)
      RA_MASK:   cfg_rdata[CHK_W-1:0] = mask_q;
      RA_SECT:   cfg_rdata[1:0]       = sect_q;
      RA_TYPE:   cfg_rdata[2:0]       = type_q;
      RA_ARM:    cfg_rdata[0]         = armed_q;
      RA_RDTRIG: cfg_rdata[0]         = rdtrig_q;
      RA_CNT:    cfg_rdata[CNT_W-1:0] = cnt_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/ecc_inj_match.sv
module ecc_inj_match
  import ecc_inj_pkg::*;
#(
  parameter int MAXW = 16
) (
  input  logic [NUM_FIELDS-1:0][MAXW-1:0] fld_val,
  input  logic [NUM_FIELDS-1:0]           fld_any,
  input  logic [NUM_FIELDS-1:0][MAXW-1:0] acc_fld,
  output logic [NUM_FIELDS-1:0]           fld_hit,
  output logic                            addr_hit
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign fld_hit[g] = fld_any[g] || (fld_val[g] == acc_fld[g]);
  end

  assign addr_hit = &fld_hit;
endmodule

// File: rtl/ecc_inj_corrupt.sv
module ecc_inj_corrupt #(
  parameter int CHK_W = 16
) (
  input  logic             fire,
  input  logic             use_ecc,
  input  logic             use_par,
  input  logic [CHK_W-1:0] mask,
  input  logic [1:0]       sect,
  input  logic [CHK_W-1:0] chk_in,
  input  logic [1:0]       par_in,
  output logic [CHK_W-1:0] chk_flip,
  output logic [1:0]       par_flip,
  output logic [CHK_W-1:0] chk_out,
  output logic [1:0]       par_out
);
  localparam int HALF = CHK_W / 2;

  function automatic logic [CHK_W-1:0] lane_sel(input logic [1:0] s);
    logic [CHK_W-1:0] r;
    r = '0;
    if (s[0]) r[HALF-1:0]     = '1;
    if (s[1]) r[CHK_W-1:HALF] = '1;
    return r;
  endfunction

  assign chk_flip = (fire && use_ecc) ? (mask & lane_sel(sect)) : '0;
  assign par_flip = (fire && use_par) ? sect : 2'b00;
  assign chk_out  = chk_in ^ chk_flip;
  assign par_out  = par_in ^ par_flip;
endmodule

// File: rtl/ecc_inject_unit.sv
module ecc_inject_unit
  import ecc_inj_pkg::*;
#(
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 12,
  parameter int CHK_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [DIMM_W-1:0] acc_dimm,
  input  logic [RANK_W-1:0] acc_rank,
  input  logic [CHAN_W-1:0] acc_chan,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic [COL_W-1:0]  acc_col,
  input  logic [CHK_W-1:0]  chk_in,
  input  logic [1:0]        par_in,
  output logic [CHK_W-1:0]  chk_out,
  output logic [1:0]        par_out,
  output logic              inj_event
);
  localparam int MAXW = fmax(fmax(fmax(DIMM_W, RANK_W), fmax(CHAN_W, BANK_W)),
                             fmax(PAGE_W, COL_W));

  function automatic logic [NUM_FIELDS-1:0][MAXW-1:0] build_masks();
    logic [NUM_FIELDS-1:0][MAXW-1:0] m;
    m[0] = MAXW'((64'd1 << DIMM_W) - 1);
    m[1] = MAXW'((64'd1 << RANK_W) - 1);
    m[2] = MAXW'((64'd1 << CHAN_W) - 1);
    m[3] = MAXW'((64'd1 << BANK_W) - 1);
    m[4] = MAXW'((64'd1 << PAGE_W) - 1);
    m[5] = MAXW'((64'd1 << COL_W) - 1);
    return m;
  endfunction

  localparam logic [NUM_FIELDS-1:0][MAXW-1:0] FLD_MASK = build_masks();

  logic [NUM_FIELDS-1:0][MAXW-1:0] fld_val, acc_fld;
  logic [NUM_FIELDS-1:0]           fld_any, fld_hit;
  logic [CHK_W-1:0]                mask_q, chk_flip;
  logic [1:0]                      sect_q, par_flip;
  logic [2:0]                      type_q;
  logic [CNT_W-1:0]                cnt_q;
  logic armed, rd_trig_en, addr_hit, trig, corrupt_fire;
  logic arm_wr, cnt_clr, repeat_on;

  assign acc_fld[0] = MAXW'(acc_dimm);
  assign acc_fld[1] = MAXW'(acc_rank);
  assign acc_fld[2] = MAXW'(acc_chan);
  assign acc_fld[3] = MAXW'(acc_bank);
  assign acc_fld[4] = MAXW'(acc_page);
  assign acc_fld[5] = MAXW'(acc_col);

  // named internal events for the checker
  assign trig         = armed && acc_valid && addr_hit && (acc_write || rd_trig_en);
  assign corrupt_fire = trig && acc_write;
  assign arm_wr       = cfg_wr && (cfg_addr == RA_ARM);
  assign cnt_clr      = cfg_wr && (cfg_addr == RA_CNT);
  assign repeat_on    = type_q[TYP_REPEAT];
  assign inj_event    = trig;

  ecc_inj_cfg #(
    .MAXW(MAXW), .CHK_W(CHK_W), .CNT_W(CNT_W), .FLD_MASK(FLD_MASK)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .trig(trig),
    .fld_val(fld_val), .fld_any(fld_any),
    .mask_q(mask_q), .sect_q(sect_q), .type_q(type_q),
    .armed_q(armed), .rdtrig_q(rd_trig_en), .cnt_q(cnt_q)
  );

  ecc_inj_match #(.MAXW(MAXW)) match_i (
    .fld_val(fld_val), .fld_any(fld_any), .acc_fld(acc_fld),
    .fld_hit(fld_hit), .addr_hit(addr_hit)
  );

  ecc_inj_corrupt #(.CHK_W(CHK_W)) corrupt_i (
    .fire(corrupt_fire),
    .use_ecc(type_q[TYP_ECC]), .use_par(type_q[TYP_PAR]),
    .mask(mask_q), .sect(sect_q),
    .chk_in(chk_in), .par_in(par_in),
    .chk_flip(chk_flip), .par_flip(par_flip),
    .chk_out(chk_out), .par_out(par_out)
  );
endmodule

// File: rtl/ecc_inj_checker.sv
module ecc_inj_checker #(
  parameter int CHK_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic             trig,
  input logic             inj_event,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             rd_trig_en,
  input logic             repeat_on,
  input logic             arm_wr,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CHK_W-1:0] chk_in,
  input logic [CHK_W-1:0] chk_out,
  input logic [1:0]       par_in,
  input logic [1:0]       par_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_EVENT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    inj_event |-> (armed && acc_valid)); // R5
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !repeat_on && !arm_wr) |=> !armed); // R6
  AST_REPEAT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && repeat_on && !arm_wr) |=> armed); // R7
  AST_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |-> (chk_out == chk_in && par_out == par_in)); // R8
  AST_READ_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_event && !acc_write) |-> rd_trig_en); // R8
  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_event |-> (chk_out == chk_in && par_out == par_in)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !cnt_clr && cnt_q != CNT_MAX) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !cnt_clr) |=> cnt_q == CNT_MAX); // R9
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt_q == '0); // R9
endmodule

bind ecc_inject_unit ecc_inj_checker #(.CHK_W(CHK_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .armed(armed), .trig(trig), .inj_event(inj_event),
  .acc_valid(acc_valid), .acc_write(acc_write), .rd_trig_en(rd_trig_en),
  .repeat_on(repeat_on), .arm_wr(arm_wr), .cnt_clr(cnt_clr), .cnt_q(cnt_q),
  .chk_in(chk_in), .chk_out(chk_out), .par_in(par_in), .par_out(par_out)
);

// File: tb/ecc_inject_unit_tb_top.sv
module ecc_inject_unit_tb_top;
  localparam logic [3:0] A_DIMM = 0, A_RANK = 1, A_CHAN = 2, A_BANK = 3, A_PAGE = 4,
                         A_COL = 5, A_MASK = 6, A_SECT = 7, A_TYPE = 8, A_ARM = 9,
                         A_RDT = 10, A_CNT = 11;
  localparam logic [31:0] ANY = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_dimm = '0, acc_rank = '0, acc_chan = '0;
  logic [2:0]  acc_bank = '0;
  logic [15:0] acc_page = '0;
  logic [11:0] acc_col = '0;
  logic [15:0] chk_in = '0, chk_out;
  logic [1:0]  par_in = '0, par_out;
  logic        inj_event;

  int total = 0, bad = 0;
  logic [15:0] g_chk;
  logic [1:0]  g_par;
  logic        g_evt;

  always #10 clk = ~clk;

  ecc_inject_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_dimm(acc_dimm),
    .acc_rank(acc_rank), .acc_chan(acc_chan), .acc_bank(acc_bank),
    .acc_page(acc_page), .acc_col(acc_col), .chk_in(chk_in), .par_in(par_in),
    .chk_out(chk_out), .par_out(par_out), .inj_event(inj_event)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #2;
    check(cfg_rdata, exp, tag);
  endtask

  task automatic access(input logic w, input logic [1:0] dm, input logic [1:0] rk,
                        input logic [1:0] ch, input logic [2:0] bk, input logic [15:0] pg,
                        input logic [11:0] cl, input logic [15:0] c, input logic [1:0] p);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_dimm = dm; acc_rank = rk; acc_chan = ch;
    acc_bank = bk; acc_page = pg; acc_col = cl; chk_in = c; par_in = p;
    #2;
    g_chk = chk_out; g_par = par_out; g_evt = inj_event;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 6; i++) rd_check(4'(i), ANY, "R1 match wildcard after reset");
    rd_check(A_MASK, 0, "R1 mask reset");
    rd_check(A_SECT, 0, "R1 section reset");
    rd_check(A_TYPE, 0, "R1 type reset");
    rd_check(A_ARM, 0, "R1 arm reset");
    rd_check(A_RDT, 0, "R1 R8 read-trigger reset");
    rd_check(A_CNT, 0, "R1 count reset");
  endtask

  task automatic t_readback;
    wr(A_MASK, 32'h0000_A5A5); rd_check(A_MASK, 32'h0000_A5A5, "R10 mask readback");
    wr(A_SECT, 2);             rd_check(A_SECT, 2, "R10 section readback");
    wr(A_TYPE, 5);             rd_check(A_TYPE, 5, "R10 type readback");
    wr(A_RDT, 1);              rd_check(A_RDT, 1, "R10 read-trigger readback");
    wr(A_CHAN, 7);             rd_check(A_CHAN, 3, "R10 channel truncated");
    wr(A_PAGE, 32'h8000_1234); rd_check(A_PAGE, 32'h8000_1234, "R10 page with wildcard");
    wr(A_CHAN, ANY); wr(A_PAGE, ANY); wr(A_RDT, 0);
  endtask

  task automatic t_wildcard;
    wr(A_MASK, 16'h0040); wr(A_SECT, 3); wr(A_TYPE, 3); wr(A_ARM, 1);
    access(1, 2'd1, 2'd3, 2'd2, 3'd5, 16'hBEEF, 12'h3AB, 16'h1234, 2'b00);
    check(g_chk, 16'h1274, "R2 R3 wildcard write single-bit flip");
    check(g_evt, 1, "R11 event on trigger");
    access(1, 2'd0, 2'd0, 2'd0, 3'd0, 16'h0000, 12'h000, 16'h0040, 2'b00);
    check(g_chk, 16'h0000, "R2 R7 wildcard second address");
  endtask

  task automatic t_sections;
    wr(A_MASK, 16'hFFFF);
    wr(A_SECT, 1);
    access(1, 0, 0, 0, 0, 0, 0, 16'h0F0F, 2'b00);
    check(g_chk, 16'h0FF0, "R3 low section only");
    wr(A_SECT, 2);
    access(1, 0, 0, 0, 0, 0, 0, 16'h0F0F, 2'b00);
    check(g_chk, 16'hF00F, "R3 high section only");
    wr(A_SECT, 0);
    access(1, 0, 0, 0, 0, 0, 0, 16'h0F0F, 2'b00);
    check(g_chk, 16'h0F0F, "R3 section zero no flip");
    check(g_evt, 1, "R11 event with section zero");
    wr(A_SECT, 3);
  endtask

  task automatic t_field_match;
    wr(A_MASK, 16'h0001); wr(A_CHAN, 2); wr(A_RANK, 1);
    access(1, 3, 1, 2, 7, 16'h5555, 12'h111, 16'h0000, 2'b00);
    check({g_evt, g_chk}, {1'b1, 16'h0001}, "R2 channel+rank hit");
    access(1, 3, 1, 1, 7, 16'h5555, 12'h111, 16'h0000, 2'b00);
    check({g_evt, g_chk}, {1'b0, 16'h0000}, "R2 channel miss");
    access(1, 3, 0, 2, 7, 16'h5555, 12'h111, 16'h0000, 2'b00);
    check({g_evt, g_chk}, {1'b0, 16'h0000}, "R2 rank miss");
    wr(A_PAGE, 16'h1ABC);
    access(1, 0, 1, 2, 0, 16'h1ABC, 12'h000, 16'h0000, 2'b00);
    check(g_evt, 1, "R2 page hit");
    access(1, 0, 1, 2, 0, 16'h1ABD, 12'h000, 16'h0000, 2'b00);
    check(g_evt, 0, "R2 page miss");
    wr(A_CHAN, ANY); wr(A_RANK, ANY); wr(A_PAGE, ANY);
    access(1, 0, 0, 1, 0, 16'h1ABD, 12'h000, 16'h0000, 2'b00);
    check(g_evt, 1, "R2 wildcards restored");
  endtask

  task automatic t_parity;
    wr(A_MASK, 16'h0101); wr(A_TYPE, 7); wr(A_SECT, 1);
    access(1, 0, 0, 0, 0, 0, 0, 16'h0000, 2'b10);
    check({g_chk, 14'd0, g_par}, {16'h0001, 14'd0, 2'b11}, "R4 parity low section plus ecc");
    wr(A_SECT, 3);
    access(1, 0, 0, 0, 0, 0, 0, 16'h0000, 2'b10);
    check({g_chk, 14'd0, g_par}, {16'h0101, 14'd0, 2'b01}, "R4 parity both sections");
    wr(A_TYPE, 5);
    access(1, 0, 0, 0, 0, 0, 0, 16'h00FF, 2'b00);
    check({g_chk, 14'd0, g_par}, {16'h00FF, 14'd0, 2'b11}, "R4 parity only, ecc untouched");
  endtask

  task automatic t_arm;
    wr(A_TYPE, 3); wr(A_MASK, 16'h8000);
    wr(A_ARM, 32'h0000_0500);
    rd_check(A_ARM, 1, "R5 nonzero write arms");
    wr(A_ARM, 0);
    rd_check(A_ARM, 0, "R5 zero write disarms");
    access(1, 0, 0, 0, 0, 0, 0, 16'h0000, 2'b00);
    check({g_evt, g_chk}, {1'b0, 16'h0000}, "R5 disarmed no injection");
  endtask

  task automatic t_oneshot;
    wr(A_TYPE, 2); wr(A_MASK, 16'h0040); wr(A_ARM, 1);
    access(1, 0, 0, 0, 0, 0, 0, 16'h0000, 2'b00);
    check({g_evt, g_chk}, {1'b1, 16'h0040}, "R6 first write corrupted");
    rd_check(A_ARM, 0, "R6 self disarm");
    access(1, 0, 0, 0, 0, 0, 0, 16'h0000, 2'b00);
    check({g_evt, g_chk}, {1'b0, 16'h0000}, "R6 second write clean");
  endtask

  task automatic t_read;
    wr(A_TYPE, 3); wr(A_MASK, 16'h00FF); wr(A_SECT, 3); wr(A_ARM, 1); wr(A_CNT, 0);
    access(0, 0, 0, 0, 0, 0, 0, 16'h5555, 2'b01);
    check({g_evt, g_chk}, {1'b0, 16'h5555}, "R8 read ignored by default");
    rd_check(A_CNT, 0, "R8 read not counted");
    wr(A_RDT, 1);
    access(0, 0, 0, 0, 0, 0, 0, 16'h5555, 2'b01);
    check({g_evt, g_chk, 14'd0, g_par}, {1'b1, 16'h5555, 14'd0, 2'b01}, "R8 read trigger, data clean");
    rd_check(A_CNT, 1, "R8 R9 read trigger counted");
    wr(A_RDT, 0);
  endtask

  task automatic t_count;
    wr(A_CNT, 0);
    rd_check(A_CNT, 0, "R9 count cleared");
    for (int i = 0; i < 3; i++) access(1, 0, 0, 0, 0, 0, 0, 16'h0000, 2'b00);
    rd_check(A_CNT, 3, "R9 three injections");
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1;
    repeat (65540) @(negedge clk);
    acc_valid = 1'b0;
    rd_check(A_CNT, 32'h0000_FFFF, "R9 saturation");
    @(negedge clk);
    acc_valid = 1'b1; cfg_wr = 1'b1; cfg_addr = A_CNT; cfg_wdata = 0;
    @(negedge clk);
    acc_valid = 1'b0; cfg_wr = 1'b0;
    rd_check(A_CNT, 0, "R9 clear beats trigger");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_wildcard();
    t_sections();
    t_field_match();
    t_parity();
    t_arm();
    t_oneshot();
    t_read();
    t_count();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule